// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers three interrupt sources from a graphics engine (binner flush done, render frame done, and binner out of memory) into one registered interrupt line. Software sees a pending-status register whose bits are cleared by writing ones. The enable mask is changed only through two strobe-style registers: one sets enable bits and one clears them. Both of these registers read back the same mask. The interrupt line is high whenever a pending bit is also enabled.

The two done sources are single-cycle pulses that stay latched until software acknowledges them. The out-of-memory source works differently. A pulse from the binner raises a held condition, and that condition keeps re-setting its status bit until software hands the binner fresh memory. Software does this by writing a pool base address and then a pool size. The block keeps both values and drives them to the binner, together with a one-cycle load strobe.

The register port is a simple synchronous bus. Writes take effect at the clock edge. Read data is registered and is valid on the cycle after the read strobe.

Top module: `gpu_irq_ctrl`

## Requirements
- R1: After synchronous reset the following are all zero: the pending bits, the enable mask, the pool base, the pool size, the held out-of-memory condition, `irq`, `pool_load` and `bus_rdata`.
- R2: Pending bits are read at offset 0, with bit 0 = out of memory, bit 1 = flush done, bit 2 = frame done, and bits above 2 reading as zero. A one-cycle pulse on `ev_flush_done` or `ev_frame_done` sets its bit, and the bit stays set until it is acknowledged.
- R3: Writing offset 0 clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If a source sets a pending bit in the same cycle that software clears it, the bit stays set.
- R5: Writing offset 1 enables each source whose data bit is 1. Bits written as 0 leave the mask unchanged.
- R6: Writing offset 2 disables each source whose data bit is 1. Bits written as 0 leave the mask unchanged.
- R7: Reads of offset 1 and offset 2 both return the enable mask in bits 2:0, with zero above.
- R8: `irq` is a register that is high on the cycle after any pending bit is also enabled, and low on the cycle after none is.
- R9: A pulse on `ev_out_of_mem` raises a held condition. While the condition holds, pending bit 0 is set again on every cycle, so acknowledging it does not remove it.
- R10: Offset 3 holds the pool base and offset 4 holds the pool size, and both read back. A size write that follows a base write (with no completed load in between) clears the held condition and pulses `pool_load` for one cycle. A size write without a fresh base write stores the size but leaves the condition and `pool_load` untouched. If a new out-of-memory pulse arrives in the same cycle as the load, the condition stays held.
- R11: `bus_rdata` shows the register contents from before the edge at which `bus_re` was sampled. Unmapped offsets read as zero, and the output is zero on cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| ev_flush_done | input | 1 | Binner flush-done pulse |
| ev_frame_done | input | 1 | Render frame-done pulse |
| ev_out_of_mem | input | 1 | Binner out-of-memory pulse |
| pool_base | output | DATA_W | Overflow pool base address |
| pool_size | output | DATA_W | Overflow pool size |
| pool_load | output | 1 | One-cycle strobe when a new pool is handed over |
| irq | output | 1 | Registered interrupt line |

## Verification
Event pulses, writes and pool loads update the held state at the edge where they are sampled. As a result, the pending bits, the mask and the pool values are due one cycle after the stimulus, as is `pool_load`. Read data is due one cycle after `bus_re`. `irq` trails the pending and mask state by one further register, so it responds two cycles after an event.

The bench drives inputs at the falling edge and samples one time unit after the rising edge. At that point it advances a bench-side model by the same edge and compares against it, so every comparison lines up with the register count of its path. The directed cases (a collision between a set and a clear, zero bits ignored, a size write without a base write, and a load colliding with a new out-of-memory pulse) use the same sampling point. They read the state back through the bus on the following cycle.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int NSRC = 3;
  localparam int SRC_OOM   = 0;
  localparam int SRC_FLUSH = 1;
  localparam int SRC_FRAME = 2;

  localparam int OFS_PENDING = 0;
  localparam int OFS_EN_SET  = 1;
  localparam int OFS_EN_CLR  = 2;
  localparam int OFS_BASE    = 3;
  localparam int OFS_SIZE    = 4;
endpackage

// File: rtl/gic_pending.sv
module gic_pending #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign pend_o[i] = q;

    // R4: a set in the same cycle as a clear leaves the bit high
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> pend_o[i]);
    // R3: a clear with no set drops the bit
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    // R3: with neither a set nor a clear the bit holds
    a_r3_zero_holds: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(pend_o[i]));
  end
endmodule

// File: rtl/gic_mask.sv
module gic_mask #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (set_wr) en_q <= en_q | wbits;
    else if (clr_wr) en_q <= en_q & ~wbits;
  end
  assign en_o = en_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5: a set write with a one in this bit enables the source
    a_r5_set_bit: assert property (@(posedge clk) disable iff (rst)
      (set_wr && wbits[i]) |=> en_o[i]);
    // R6: a clear write with a one in this bit disables the source
    a_r6_clr_bit: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && !set_wr && wbits[i]) |=> !en_o[i]);
    // R5 / R6: a zero data bit leaves the mask bit untouched
    a_r6_zero_ignored: assert property (@(posedge clk) disable iff (rst)
      ((set_wr || clr_wr) && !wbits[i]) |=> $stable(en_o[i]));
  end
endmodule

// File: rtl/gic_pool.sv
module gic_pool #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr,
  input  logic          size_wr,
  input  logic [DW-1:0] wdata,
  input  logic          oom_evt,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] size_o,
  output logic          load_o,
  output logic          oom_hold_o
);
  logic [DW-1:0] base_q, size_q;
  logic          armed_q, load_q, hold_q;
  logic          accept;

  assign accept = size_wr && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      size_q  <= '0;
      armed_q <= 1'b0;
      load_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      if (base_wr) base_q <= wdata;
      if (size_wr) size_q <= wdata;
      if (base_wr)     armed_q <= 1'b1;
      else if (accept) armed_q <= 1'b0;
      load_q <= accept;
      hold_q <= oom_evt || (hold_q && !accept);
    end
  end

  assign base_o     = base_q;
  assign size_o     = size_q;
  assign load_o     = load_q;
  assign oom_hold_o = hold_q;

  // R10: the load strobe lasts one cycle
  a_r10_load_single: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);
  // R10: a size write without a fresh base write keeps the condition
  a_r10_unarmed_size: assert property (@(posedge clk) disable iff (rst)
    (size_wr && !armed_q && !oom_evt) |=> ($stable(oom_hold_o) && !load_o));
  // R9: an out-of-memory pulse always leaves the condition held
  a_r9_evt_holds: assert property (@(posedge clk) disable iff (rst)
    oom_evt |=> oom_hold_o);
endmodule

// File: rtl/gpu_irq_ctrl.sv
module gpu_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_flush_done,
  input  logic              ev_frame_done,
  input  logic              ev_out_of_mem,
  output logic [DATA_W-1:0] pool_base,
  output logic [DATA_W-1:0] pool_size,
  output logic              pool_load,
  output logic              irq
);
  import gic_pkg::*;

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(OFS_EN_CLR);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFS_BASE);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(OFS_SIZE);

  logic [NSRC-1:0] pend, en, set_v, clr_v;
  logic            wr_pend, wr_eset, wr_eclr, wr_base, wr_size;
  logic            oom_hold;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic            irq_q;

  assign wr_pend = bus_we && (bus_addr == A_PEND);
  assign wr_eset = bus_we && (bus_addr == A_ESET);
  assign wr_eclr = bus_we && (bus_addr == A_ECLR);
  assign wr_base = bus_we && (bus_addr == A_BASE);
  assign wr_size = bus_we && (bus_addr == A_SIZE);

  always_comb begin
    set_v            = '0;
    set_v[SRC_OOM]   = ev_out_of_mem || oom_hold;
    set_v[SRC_FLUSH] = ev_flush_done;
    set_v[SRC_FRAME] = ev_frame_done;
    clr_v            = wr_pend ? bus_wdata[NSRC-1:0] : '0;
  end

  gic_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
  );

  gic_mask #(.N(NSRC)) u_mask (
    .clk(clk), .rst(rst), .set_wr(wr_eset), .clr_wr(wr_eclr),
    .wbits(bus_wdata[NSRC-1:0]), .en_o(en)
  );

  gic_pool #(.DW(DATA_W)) u_pool (
    .clk(clk), .rst(rst), .base_wr(wr_base), .size_wr(wr_size),
    .wdata(bus_wdata), .oom_evt(ev_out_of_mem),
    .base_o(pool_base), .size_o(pool_size), .load_o(pool_load),
    .oom_hold_o(oom_hold)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_PEND:         rd_mux[NSRC-1:0] = pend;
      A_ESET, A_ECLR: rd_mux[NSRC-1:0] = en;
      A_BASE:         rd_mux = pool_base;
      A_SIZE:         rd_mux = pool_size;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= bus_re ? rd_mux : '0;
      irq_q   <= |(pend & en);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R8: an enabled pending source raises the line one cycle later
  a_r8_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(pend & en)) |=> irq);
  // R8: with nothing enabled and pending the line falls one cycle later
  a_r8_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & en)) |=> !irq);
  // R9: while the condition holds, bit 0 stays pending
  a_r9_oom_sticky: assert property (@(posedge clk) disable iff (rst)
    oom_hold |=> pend[SRC_OOM]);
  // R11: no read strobe gives zero read data
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));
endmodule

// File: tb/sim_gpu_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpu_irq_ctrl;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [DW-1:0] bus_rdata, pool_base, pool_size;
  logic          ev_flush_done = 1'b0, ev_frame_done = 1'b0, ev_out_of_mem = 1'b0;
  logic          pool_load, irq;

  always #4 clk = ~clk;

  gpu_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ev_flush_done(ev_flush_done), .ev_frame_done(ev_frame_done),
    .ev_out_of_mem(ev_out_of_mem), .pool_base(pool_base),
    .pool_size(pool_size), .pool_load(pool_load), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [2:0]    m_st, m_en;
  logic          m_hold, m_arm, m_load, m_irq;
  logic [DW-1:0] m_base, m_size, m_rd;

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      4'd0:       return {29'd0, m_st};
      4'd1, 4'd2: return {29'd0, m_en};
      4'd3:       return m_base;
      4'd4:       return m_size;
      default:    return '0;
    endcase
  endfunction

  task automatic model_reset();
    m_st = '0; m_en = '0; m_hold = 0; m_arm = 0; m_load = 0; m_irq = 0;
    m_base = '0; m_size = '0; m_rd = '0;
  endtask

  task automatic model_step();
    logic [2:0] setv, clrv;
    logic acc;
    m_rd  = bus_re ? model_read(bus_addr) : '0;
    m_irq = |(m_st & m_en);
    setv  = {ev_frame_done, ev_flush_done, ev_out_of_mem | m_hold};
    clrv  = (bus_we && bus_addr == 4'd0) ? bus_wdata[2:0] : 3'd0;
    m_st  = (m_st & ~clrv) | setv;
    if (bus_we && bus_addr == 4'd1) m_en = m_en | bus_wdata[2:0];
    else if (bus_we && bus_addr == 4'd2) m_en = m_en & ~bus_wdata[2:0];
    acc = bus_we && bus_addr == 4'd4 && m_arm;
    if (bus_we && bus_addr == 4'd3) m_base = bus_wdata;
    if (bus_we && bus_addr == 4'd4) m_size = bus_wdata;
    if (bus_we && bus_addr == 4'd3) m_arm = 1;
    else if (acc) m_arm = 0;
    m_load = acc;
    m_hold = ev_out_of_mem | (m_hold & ~acc);
  endtask

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R8"},  "irq",       {31'd0, irq},       {31'd0, m_irq});
    check({tag, " R11"}, "rdata",     bus_rdata,          m_rd);
    check({tag, " R10"}, "pool_load", {31'd0, pool_load}, {31'd0, m_load});
    check({tag, " R10"}, "pool_base", pool_base,          m_base);
    check({tag, " R10"}, "pool_size", pool_size,          m_size);
  endtask

  // one cycle: drive at the falling edge, sample just after the rising edge
  task automatic cyc(input logic we, input logic re, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic fl, input logic fr,
                     input logic om);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    ev_flush_done = fl; ev_frame_done = fr; ev_out_of_mem = om;
    @(posedge clk);
    #1;
    model_step();
    check_all("model");
  endtask

  task automatic idle(); cyc(0, 0, 4'd0, '0, 0, 0, 0); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1, 0, a, d, 0, 0, 0);
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    cyc(0, 1, a, '0, 0, 0, 0);
    v = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] v;
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    // R1: reset state
    check("R1", "irq", {31'd0, irq}, '0);
    check("R1", "rdata", bus_rdata, '0);
    check("R1", "pool_base", pool_base, '0);
    check("R1", "pool_size", pool_size, '0);
    rd(4'd0, v); check("R1", "pending", v, '0);
    rd(4'd1, v); check("R1", "mask", v, '0);

    // R2: flush pulse latches bit 1; R8 stays low while masked
    cyc(0, 0, 4'd0, '0, 1, 0, 0);
    idle(); idle();
    rd(4'd0, v); check("R2", "flush latched", v, 32'h2);
    check("R8", "masked irq", {31'd0, irq}, '0);
    // R5: set bits 1 and 2, zero bit 0 ignored
    wr(4'd1, 32'h6);
    rd(4'd2, v); check("R7", "mask via clr ofs", v, 32'h6);
    idle(); check("R8", "irq raised", {31'd0, irq}, 32'h1);
    // R6: clear bit 2 only; zero bits ignored
    wr(4'd2, 32'h4);
    rd(4'd1, v); check("R6", "mask after clr", v, 32'h2);
    // R4: frame event collides with clear of bit 2 -> stays set
    cyc(1, 0, 4'd0, 32'h4, 0, 1, 0);
    rd(4'd0, v); check("R4", "set wins", v, 32'h6);
    // R3: clear bit 1 only, bit 2 untouched
    wr(4'd0, 32'h2);
    rd(4'd0, v); check("R3", "w1c partial", v, 32'h4);
    idle(); check("R8", "irq dropped", {31'd0, irq}, '0);
    wr(4'd0, 32'hFFFF_FFF8);
    rd(4'd0, v); check("R3", "zero bits keep", v, 32'h4);
    wr(4'd0, 32'h4);

    // R9: out-of-memory is sticky through acknowledge
    cyc(0, 0, 4'd0, '0, 0, 0, 1);
    wr(4'd0, 32'h1);
    idle();
    rd(4'd0, v); check("R9", "oom reasserts", v, 32'h1);
    // R10: size without base keeps condition
    wr(4'd4, 32'h1000);
    idle();
    wr(4'd0, 32'h1); idle();
    rd(4'd0, v); check("R10", "unarmed size keeps oom", v, 32'h1);
    // R10: base then size hands over pool
    wr(4'd3, 32'hCAFE_0000);
    wr(4'd4, 32'h0002_0000);
    check("R10", "load pulse", {31'd0, pool_load}, 32'h1);
    idle(); check("R10", "load ends", {31'd0, pool_load}, '0);
    wr(4'd0, 32'h1);
    rd(4'd0, v); check("R9", "oom cleared after load", v, '0);
    rd(4'd3, v); check("R10", "base readback", v, 32'hCAFE_0000);
    rd(4'd4, v); check("R10", "size readback", v, 32'h0002_0000);
    // R10: load colliding with a fresh oom pulse keeps condition
    wr(4'd3, 32'h10);
    cyc(1, 0, 4'd4, 32'h20, 0, 0, 1);
    idle(); wr(4'd0, 32'h1); idle();
    rd(4'd0, v); check("R10", "oom beats load", v, 32'h1);
    // R11: unmapped offset reads zero
    rd(4'd9, v); check("R11", "unmapped", v, '0);

    // random phase, checked against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom_range(0, 6));
      d = ($urandom_range(0, 3) == 0) ? $urandom() : DW'($urandom_range(0, 7));
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, d,
          $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
          $urandom_range(0, 29) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule